// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the execution stage of a small 8-bit accumulator machine that has no decimal arithmetic. Each cycle it takes an operation code, an operand-select field, the A, X, Y and stack-pointer values, a memory operand and the current carry. It returns a result byte, the new N, V, Z and C values, and a 4-bit mask that tells the register file which of those flags to write. Fetching operands, writing results back and the stack are handled outside.

The datapath is purely combinational. A parameter places an optional register on the outputs; by default it is present, so results appear one clock after the inputs. The chip has no decimal-mode input at all, so add and subtract are always binary.

Flag vector and mask bits share one layout: bit 3 is N, bit 2 is V, bit 1 is Z, bit 0 is C. The operand select `sel_i` picks the unary or compare operand: 0 is M, 1 is A, 2 is X, 3 is Y.

Top module: `acc8_exec`

## Requirements
- R1: Op code 4 (add) gives A+M+C in binary. All four flags are enabled (mask 4'b1111). C is the carry out, and V is set when both inputs share a sign that the result does not have.
- R2: Op code 5 (subtract) gives A-M-(1-C). The carry out is set when no borrow occurs. All four flags are enabled, and V flags a signed overflow.
- R3: Op code 6 (compare) outputs the selected register minus M, with no borrow-in. The mask is 4'b1011 (V not written), and C is set when the register is at least M, unsigned.
- R4: Op code 7 (bit test) outputs A AND M, with Z set when that value is zero. N is M bit 7 and V is M bit 6. The mask is 4'b1110, so C is not written.
- R5: Op code 0 (load: M), 1 (OR), 2 (AND) and 3 (XOR, each of A with M) write only N and Z (mask 4'b1010). N is result bit 7 and Z is set when the result is zero.
- R6: Op codes 8 (shift left), 9 (shift right), 10 (rotate left) and 11 (rotate right) act on the selected operand. Left moves shift old bit 7 into C, and right moves shift old bit 0 into C. Rotates fill the vacated bit with the incoming carry, while shifts fill it with 0. The mask is 4'b1011.
- R7: Op codes 12 (increment) and 13 (decrement) act on the selected operand and wrap modulo 256. They write only N and Z, so C is left untouched.
- R8: Op code 14 copies the selected operand, and op code 15 copies the stack pointer. Both write N and Z. Op code 16 outputs X for the stack pointer and writes no flag (mask 0).
- R9: A flag bit whose mask bit is 0 reads 0. Op codes 17 to 31 output result 0 and mask 0.
- R10: With the output register present, each result appears one clock after its inputs. While reset is asserted the result, flags and mask read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| sel_i | input | 2 | Unary/compare operand select: 0 M, 1 A, 2 X, 3 Y |
| a_i | input | 8 | Accumulator value |
| x_i | input | 8 | X index value |
| y_i | input | 8 | Y index value |
| s_i | input | 8 | Stack pointer value |
| m_i | input | 8 | Memory operand |
| c_i | input | 1 | Current carry flag |
| res_o | output | 8 | Result byte |
| flag_o | output | 4 | New flag values {N,V,Z,C}, masked |
| flag_we_o | output | 4 | Flag write mask {N,V,Z,C} |

## Verification
Every result, flag and mask is due exactly one clock after its inputs are applied. The bench applies inputs on a falling edge and compares on the next falling edge, so exactly one register stage lies between stimulus and sample. The stimulus does not pause between operations, so each sample also shows that nothing leaks in from the previous operation. During reset the outputs are sampled while the register is held, and they must read zero.

// File: rtl/acc8_pkg.sv
`timescale 1ns/1ps
package acc8_pkg;
  localparam int DW = 8;
  localparam int FN = 3;
  localparam int FV = 2;
  localparam int FZ = 1;
  localparam int FC = 0;

  typedef enum logic [4:0] {
    OP_LOAD = 5'd0,  OP_OR  = 5'd1,  OP_AND = 5'd2,  OP_XOR = 5'd3,
    OP_ADC  = 5'd4,  OP_SBC = 5'd5,  OP_CMP = 5'd6,  OP_BIT = 5'd7,
    OP_ASL  = 5'd8,  OP_LSR = 5'd9,  OP_ROL = 5'd10, OP_ROR = 5'd11,
    OP_INC  = 5'd12, OP_DEC = 5'd13, OP_XFR = 5'd14, OP_S2X = 5'd15,
    OP_X2S  = 5'd16
  } op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic [3:0]    flg;
    logic [3:0]    we;
  } alu_out_t;

  // carry-in adder, one bit wider than the data
  function automatic logic [DW:0] add_cy(input logic [DW-1:0] a,
                                         input logic [DW-1:0] b,
                                         input logic ci);
    return {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
  endfunction

  // signed overflow of a + b giving s
  function automatic logic add_ov(input logic [DW-1:0] a,
                                  input logic [DW-1:0] b,
                                  input logic [DW-1:0] s);
    return (a[DW-1] == b[DW-1]) && (s[DW-1] != a[DW-1]);
  endfunction

  function automatic logic is_zero(input logic [DW-1:0] v);
    return v == '0;
  endfunction
endpackage

// File: rtl/acc8_adder.sv
`timescale 1ns/1ps
module acc8_adder
  import acc8_pkg::*;
(
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] cmp_reg_i,
  input  logic [DW-1:0] m_i,
  input  logic          c_i,
  output logic          carry_o,
  output logic          ovf_o,
  output alu_out_t      out_o
);
  logic          is_cmp;
  logic          is_add;
  logic [DW-1:0] lhs;
  logic [DW-1:0] rhs;
  logic          cin;
  logic [DW:0]   sum;

  assign is_cmp  = (op_i == OP_CMP);
  assign is_add  = (op_i == OP_ADC);
  assign lhs     = is_cmp ? cmp_reg_i : a_i;
  assign rhs     = is_add ? m_i : ~m_i;
  assign cin     = is_cmp ? 1'b1 : c_i;
  assign sum     = add_cy(lhs, rhs, cin);
  assign carry_o = sum[DW];
  assign ovf_o   = add_ov(lhs, rhs, sum[DW-1:0]);

  always_comb begin
    out_o.res     = sum[DW-1:0];
    out_o.flg[FN] = sum[DW-1];
    out_o.flg[FV] = ovf_o;
    out_o.flg[FZ] = is_zero(sum[DW-1:0]);
    out_o.flg[FC] = carry_o;
    out_o.we      = is_cmp ? 4'b1011 : 4'b1111;
  end
endmodule

// File: rtl/acc8_shifter.sv
`timescale 1ns/1ps
module acc8_shifter
  import acc8_pkg::*;
(
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] opd_i,
  input  logic          c_i,
  output logic          out_bit_o,
  output alu_out_t      out_o
);
  logic          left;
  logic          rot;
  logic          fill;
  logic [DW-1:0] shifted;

  assign left      = (op_i == OP_ASL) || (op_i == OP_ROL);
  assign rot       = (op_i == OP_ROL) || (op_i == OP_ROR);
  assign fill      = rot & c_i;
  assign out_bit_o = left ? opd_i[DW-1] : opd_i[0];
  assign shifted   = left ? {opd_i[DW-2:0], fill} : {fill, opd_i[DW-1:1]};

  always_comb begin
    out_o.res     = shifted;
    out_o.flg[FN] = shifted[DW-1];
    out_o.flg[FV] = 1'b0;
    out_o.flg[FZ] = is_zero(shifted);
    out_o.flg[FC] = out_bit_o;
    out_o.we      = 4'b1011;
  end
endmodule

// File: rtl/acc8_misc.sv
`timescale 1ns/1ps
module acc8_misc
  import acc8_pkg::*;
(
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] s_i,
  input  logic [DW-1:0] m_i,
  input  logic [DW-1:0] opd_i,
  output alu_out_t      out_o
);
  logic [DW-1:0] val;
  logic [3:0]    we;
  logic          bit_test;

  assign bit_test = (op_i == OP_BIT);

  always_comb begin
    val = '0;
    we  = 4'b0000;
    case (op_i)
      OP_LOAD: begin val = m_i;         we = 4'b1010; end
      OP_OR:   begin val = a_i | m_i;   we = 4'b1010; end
      OP_AND:  begin val = a_i & m_i;   we = 4'b1010; end
      OP_XOR:  begin val = a_i ^ m_i;   we = 4'b1010; end
      OP_BIT:  begin val = a_i & m_i;   we = 4'b1110; end
      OP_INC:  begin val = opd_i + 1'b1; we = 4'b1010; end
      OP_DEC:  begin val = opd_i - 1'b1; we = 4'b1010; end
      OP_XFR:  begin val = opd_i;       we = 4'b1010; end
      OP_S2X:  begin val = s_i;         we = 4'b1010; end
      OP_X2S:  begin val = x_i;         we = 4'b0000; end
      default: begin val = '0;          we = 4'b0000; end
    endcase
  end

  always_comb begin
    out_o.res     = val;
    out_o.flg[FN] = bit_test ? m_i[DW-1] : val[DW-1];
    out_o.flg[FV] = bit_test & m_i[DW-2];
    out_o.flg[FZ] = is_zero(val);
    out_o.flg[FC] = 1'b0;
    out_o.we      = we;
  end
endmodule

// File: rtl/acc8_exec.sv
`timescale 1ns/1ps
module acc8_exec
  import acc8_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    op_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] s_i,
  input  logic [DW-1:0] m_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic [3:0]    flag_o,
  output logic [3:0]    flag_we_o
);
  logic [DW-1:0] unary_opd;
  logic          arith_hit;
  logic          shift_hit;
  logic          add_carry;
  logic          add_ovf;
  logic          shift_out_bit;
  alu_out_t      arith_out;
  alu_out_t      shift_out;
  alu_out_t      misc_out;
  alu_out_t      picked;
  alu_out_t      masked;
  alu_out_t      stage_q;

  always_comb begin
    case (sel_i)
      2'd0:    unary_opd = m_i;
      2'd1:    unary_opd = a_i;
      2'd2:    unary_opd = x_i;
      default: unary_opd = y_i;
    endcase
  end

  assign arith_hit = (op_i == OP_ADC) || (op_i == OP_SBC) || (op_i == OP_CMP);
  assign shift_hit = (op_i == OP_ASL) || (op_i == OP_LSR) ||
                     (op_i == OP_ROL) || (op_i == OP_ROR);

  acc8_adder u_adder (
    .op_i      (op_i),
    .a_i       (a_i),
    .cmp_reg_i (unary_opd),
    .m_i       (m_i),
    .c_i       (c_i),
    .carry_o   (add_carry),
    .ovf_o     (add_ovf),
    .out_o     (arith_out)
  );

  acc8_shifter u_shifter (
    .op_i      (op_i),
    .opd_i     (unary_opd),
    .c_i       (c_i),
    .out_bit_o (shift_out_bit),
    .out_o     (shift_out)
  );

  acc8_misc u_misc (
    .op_i  (op_i),
    .a_i   (a_i),
    .x_i   (x_i),
    .s_i   (s_i),
    .m_i   (m_i),
    .opd_i (unary_opd),
    .out_o (misc_out)
  );

  always_comb begin
    if (arith_hit)      picked = arith_out;
    else if (shift_hit) picked = shift_out;
    else                picked = misc_out;
    masked.res = picked.res;
    masked.flg = picked.flg & picked.we;
    masked.we  = picked.we;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= masked;
      end
    end else begin : g_comb
      assign stage_q = masked;
    end
  endgenerate

  assign res_o     = stage_q.res;
  assign flag_o    = stage_q.flg;
  assign flag_we_o = stage_q.we;
endmodule

// File: rtl/acc8_exec_chk.sv
`timescale 1ns/1ps
module acc8_exec_chk
  import acc8_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    op_i,
  input logic [DW-1:0] x_i,
  input logic [DW-1:0] m_i,
  input logic          c_i,
  input logic [DW-1:0] res_o,
  input logic [3:0]    flag_o,
  input logic [3:0]    flag_we_o
);
  logic [4:0]    p_op;
  logic [DW-1:0] p_x;
  logic [DW-1:0] p_m;
  logic          p_c;

  generate
    if (REG_OUT) begin : g_d
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          p_op <= 5'h1F; p_x <= '0; p_m <= '0; p_c <= 1'b0;
        end else begin
          p_op <= op_i; p_x <= x_i; p_m <= m_i; p_c <= c_i;
        end
      end
    end else begin : g_c
      always_comb begin
        p_op = op_i; p_x = x_i; p_m = m_i; p_c = c_i;
      end
    end
  endgenerate

  AST_ARITH_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op == OP_ADC || p_op == OP_SBC) |-> flag_we_o == 4'b1111); // R1
  AST_CMP_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op == OP_CMP) |-> flag_we_o == 4'b1011); // R3
  AST_BIT_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op == OP_BIT) |-> (flag_o[FN] == p_m[DW-1] && flag_o[FV] == p_m[DW-2] && !flag_we_o[FC])); // R4
  AST_LOGIC_NZ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op <= 5'd3) |-> flag_we_o == 4'b1010); // R5
  AST_Z_TRACKS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_o[FZ] && p_op != OP_BIT) |-> flag_o[FZ] == (res_o == '0)); // R5
  AST_ROL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op == OP_ROL) |-> (res_o[0] == p_c && flag_we_o == 4'b1011)); // R6
  AST_STEP_NO_C: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op == OP_INC || p_op == OP_DEC) |-> flag_we_o == 4'b1010); // R7
  AST_X2S_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op == OP_X2S) |-> (flag_we_o == 4'b0000 && res_o == p_x)); // R8
  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o & ~flag_we_o) == 4'b0000); // R9
  AST_SPARE_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op > 5'd16) |-> (flag_we_o == 4'b0000 && res_o == '0)); // R9
endmodule

bind acc8_exec acc8_exec_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_i      (op_i),
  .x_i       (x_i),
  .m_i       (m_i),
  .c_i       (c_i),
  .res_o     (res_o),
  .flag_o    (flag_o),
  .flag_we_o (flag_we_o)
);

// File: tb/acc8_exec_tb.sv
`timescale 1ns/1ps
module acc8_exec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op_i = '0;
  logic [1:0] sel_i = '0;
  logic [7:0] a_i = '0, x_i = '0, y_i = '0, s_i = '0, m_i = '0;
  logic       c_i = 1'b0;
  logic [7:0] res_o;
  logic [3:0] flag_o, flag_we_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  acc8_exec #(.REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .sel_i(sel_i),
    .a_i(a_i), .x_i(x_i), .y_i(y_i), .s_i(s_i), .m_i(m_i), .c_i(c_i),
    .res_o(res_o), .flag_o(flag_o), .flag_we_o(flag_we_o)
  );

  function automatic string req_of(input int op);
    if (op == 4) return "R1";
    if (op == 5) return "R2";
    if (op == 6) return "R3";
    if (op == 7) return "R4";
    if (op <= 3) return "R5";
    if (op <= 11) return "R6";
    if (op <= 13) return "R7";
    if (op <= 16) return "R8";
    return "R9";
  endfunction

  // returns {res, flags, mask}; flags already masked
  function automatic logic [15:0] model(input int op, input int sel,
      input int a, input int x, input int y, input int s, input int m, input int c);
    int u, r, t, sa, sm, sv;
    logic n, v, z, cy;
    logic [3:0] we;
    u = (sel == 0) ? m : (sel == 1) ? a : (sel == 2) ? x : y;
    r = 0; n = 0; v = 0; z = 0; cy = 0; we = 4'b0000;
    sa = (a > 127) ? a - 256 : a;
    sm = (m > 127) ? m - 256 : m;
    case (op)
      0: begin r = m; we = 4'b1010; end
      1: begin r = a | m; we = 4'b1010; end
      2: begin r = a & m; we = 4'b1010; end
      3: begin r = a ^ m; we = 4'b1010; end
      4: begin t = a + m + c; r = t % 256; cy = (t > 255);
               sv = sa + sm + c; v = (sv > 127 || sv < -128); we = 4'b1111; end
      5: begin t = a - m - (1 - c); r = (t + 256) % 256; cy = (t >= 0);
               sv = sa - sm - (1 - c); v = (sv > 127 || sv < -128); we = 4'b1111; end
      6: begin r = (u - m + 256) % 256; cy = (u >= m); we = 4'b1011; end
      7: begin r = a & m; we = 4'b1110; end
      8: begin r = (u * 2) % 256; cy = (u >= 128); we = 4'b1011; end
      9: begin r = u / 2; cy = (u % 2 == 1); we = 4'b1011; end
      10: begin r = (u * 2) % 256 + c; cy = (u >= 128); we = 4'b1011; end
      11: begin r = u / 2 + 128 * c; cy = (u % 2 == 1); we = 4'b1011; end
      12: begin r = (u + 1) % 256; we = 4'b1010; end
      13: begin r = (u + 255) % 256; we = 4'b1010; end
      14: begin r = u; we = 4'b1010; end
      15: begin r = s; we = 4'b1010; end
      16: begin r = x; we = 4'b0000; end
      default: begin r = 0; we = 4'b0000; end
    endcase
    n = (r >= 128);
    z = (r == 0);
    if (op == 7) begin n = (m >= 128); v = ((m / 64) % 2 == 1); end
    return {r[7:0], ({n, v, z, cy} & we), we};
  endfunction

  task automatic run(input int op, input int sel, input int a, input int x,
                     input int y, input int s, input int m, input int c);
    logic [15:0] exp;
    op_i = op[4:0]; sel_i = sel[1:0]; a_i = a[7:0]; x_i = x[7:0];
    y_i = y[7:0]; s_i = s[7:0]; m_i = m[7:0]; c_i = c[0];
    exp = model(op, sel, a, x, y, s, m, c);
    @(negedge clk);
    n_chk++;
    if ({res_o, flag_o, flag_we_o} !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d sel=%0d a=%h x=%h y=%h s=%h m=%h c=%0d: got res=%h flg=%b we=%b, expected res=%h flg=%b we=%b",
               req_of(op), op, sel, a[7:0], x[7:0], y[7:0], s[7:0], m[7:0], c,
               res_o, flag_o, flag_we_o, exp[15:8], exp[7:4], exp[3:0]);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    process::self().srandom(32'd1357);
    // R10: outputs held at zero during reset, even with live inputs
    op_i = 5'd4; a_i = 8'hFF; m_i = 8'h01; c_i = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if ({res_o, flag_o, flag_we_o} !== 16'h0000) begin
      n_fail++;
      $display("FAIL R10 reset state: got %h, expected 0000", {res_o, flag_o, flag_we_o});
    end
    rst_n = 1'b1;

    // directed corners
    run(4, 0, 8'h7F, 0, 0, 0, 8'h01, 0);   // R1 signed overflow to 0x80
    run(4, 0, 8'hFF, 0, 0, 0, 8'h00, 1);   // R1 carry out, zero
    run(5, 0, 8'h80, 0, 0, 0, 8'h01, 1);   // R2 overflow to 0x7F
    run(5, 0, 8'h00, 0, 0, 0, 8'h00, 0);   // R2 borrow in gives 0xFF
    run(6, 2, 0, 8'h40, 0, 0, 8'h40, 0);   // R3 X equal
    run(6, 3, 0, 0, 8'h10, 0, 8'h20, 1);   // R3 Y below, C clear
    run(7, 0, 8'h0F, 0, 0, 0, 8'hC0, 1);   // R4 zero AND, N V from mem
    run(8, 1, 8'h80, 0, 0, 0, 0, 0);       // R6 shift out to C, zero
    run(11, 0, 0, 0, 0, 0, 8'h01, 1);      // R6 rotate old C into bit 7
    run(10, 3, 0, 0, 8'h80, 0, 0, 1);      // R6 rotate left on Y
    run(12, 2, 0, 8'hFF, 0, 0, 0, 1);      // R7 increment wraps, C kept off
    run(13, 0, 0, 0, 0, 0, 8'h00, 1);      // R7 decrement wraps
    run(15, 0, 0, 0, 0, 8'h00, 0, 0);      // R8 stack to X, zero
    run(16, 0, 0, 8'h85, 0, 8'h11, 0, 1);  // R8 X to stack, no flags
    run(17, 1, 8'hAA, 0, 0, 0, 8'h55, 1);  // R9 spare code
    run(31, 2, 8'hAA, 8'h01, 0, 0, 8'h55, 1); // R9 spare code

    // R1 / R2: every operand pair for add and subtract, carry varied per pair
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m++) begin
        run(4, 0, a, 0, 0, 0, m, (a ^ m ^ (a >> 7)) & 1);
        run(5, 0, a, 0, 0, 0, m, 1 - ((a ^ m ^ (a >> 7)) & 1));
      end

    // mixed random traffic over all codes, spare ones included
    for (int i = 0; i < 4000; i++)
      run($urandom_range(0, 20), $urandom_range(0, 3), $urandom_range(0, 255),
          $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
          $urandom_range(0, 255), $urandom_range(0, 1));

    finished = 1'b1;
    summary();
  end

  initial begin
    #(5.0 * 180000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang, expected finish");
      summary();
    end
  end
endmodule